// File: doc/BRIEF.md
# Dual Half Lookup-Table Memory/Logic Cell

This block models the lookup-table pair of one programmable function unit. Each half owns 32 storage bits, arranged as 16 words of 2 bits. A half in memory mode works as a small RAM with an asynchronous read and a clocked write. The same half in logic mode treats its 32 stored bits as the truth table of a 5-input function. Each half picks its mode independently, so one half can hold data while the other computes logic.

Each half has a 5-bit input group. In memory mode the low four bits form the address and the top bit is that half's write enable. In logic mode all five bits are the function inputs. A write-port enable input is shared by both halves and gates every write. A join setting lets one address drive both halves, which turns the pair into a 16 x 4 RAM.

The truth table used in logic mode is the content of the RAM. It is therefore loaded by writing the half while it is in memory mode and then switching that half to logic mode. Mode settings are captured from configuration inputs on a load strobe.

Top module: `lut_pair_cell`

## Requirements
- R1: A synchronous active-high `rst` clears all stored bits, puts both halves in memory mode and turns the join off. Afterwards `f` reads 0000 for every input pattern.
- R2: Half A in memory mode reads word `a_in[3:0]` combinationally on `f[1:0]`. At a rising clock edge where `a_in[4]` and `wpe` are both 1, `wd[1:0]` is stored at that word.
- R3: Half B in memory mode reads word `b_in[3:0]` on `f[3:2]`. It stores `wd[3:2]` at a rising edge where `b_in[4]` and `wpe` are both 1.
- R4: No write occurs unless the half's write enable and `wpe` are both 1. With `wpe` at 0, neither half changes.
- R5: A read of the word being written in the same cycle returns the old data. The new data appears after the rising edge.
- R6: When join is set and both halves are in memory mode, half B is addressed by `a_in[3:0]` and `b_in[3:0]` has no effect. Writes to B still use `b_in[4]` as their enable.
- R7: A half in logic mode outputs one bit on its low output (`f[0]` for A, `f[2]` for B) and 0 on its high output (`f[1]`, `f[3]`). For inputs `x[4:0]` the bit is stored word `x[3:0]`, bit `x[4]`, so input 4 selects between the two bits of a word.
- R8: A half in logic mode ignores writes: its stored bits stay unchanged even when its input 4 and `wpe` are 1.
- R9: The halves choose their modes independently (mixed operation). Join has no effect while either half is in logic mode.
- R10: Mode settings (`cfg_logic_a`, `cfg_logic_b`, `cfg_join`; 1 means logic mode or joined) are captured at a rising edge with `cfg_load` at 1. Without `cfg_load` they are retained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Captures the mode settings |
| cfg_logic_a | input | 1 | Half A mode: 1 logic, 0 memory |
| cfg_logic_b | input | 1 | Half B mode: 1 logic, 0 memory |
| cfg_join | input | 1 | 1 joins both halves under A's address |
| a_in | input | 5 | Half A inputs: address in [3:0], write enable or logic input 4 in [4] |
| b_in | input | 5 | Half B inputs: address in [3:0], write enable or logic input 4 in [4] |
| wd | input | 4 | Write data: [1:0] to half A, [3:2] to half B |
| wpe | input | 1 | Write-port enable shared by both halves |
| f | output | 4 | Read data or logic outputs: [1:0] half A, [3:2] half B |

## Verification
The bench targets these corner cases:
- A write attempt with only one of the two enables high. A design that ORs the enables instead of ANDing them would corrupt a word that later reads back.
- A read of a word in the same cycle that it is written. A design that forwards write data would show the new value one cycle early.
- A joined write. A design that keeps B on its own address would store the data in the wrong word.
- The join setting left on while one half is in logic mode. A design that still joins would read B at the wrong word.
- A logic-mode half with input 4 and `wpe` both high. A design that still writes would change the truth table.
- Both values of input 4 in logic mode. A design that swaps the bit order would return the wrong bit.
- Mode inputs that change without a load strobe. A design that fails to retain its modes would switch mode early.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;

    // Captured mode settings of the cell
    typedef struct packed {
        logic logic_a;   // 1: half A evaluates a function
        logic logic_b;   // 1: half B evaluates a function
        logic joined;    // 1: half B follows half A's address
    } cell_mode_t;

endpackage

// File: rtl/lut_half.sv
module lut_half #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              logic_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              msb_in,
    input  logic              wpe,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } half_state_t;

    half_state_t st_d, st_q;
    logic        wr_go;

    // Next-state: a write needs memory mode, the local enable and the shared enable
    always_comb begin
        st_d  = st_q;
        wr_go = !logic_mode && msb_in && wpe;
        if (wr_go) begin
            st_d.mem[addr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Asynchronous read: a full word, or one truth-table bit picked by input 4
    always_comb begin
        rdata = '0;
        if (logic_mode) begin
            rdata[0] = st_q.mem[addr][msb_in];
        end else begin
            rdata = st_q.mem[addr];
        end
    end

    // R4 R8
    no_gated_write_chk: assert property (@(posedge clk) disable iff (rst)
        (logic_mode || !msb_in || !wpe) |=> $stable(st_q));

    // R2 R3
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (!logic_mode && msb_in && wpe) |=> (st_q.mem[$past(addr)] == $past(wdata)));

    // R7
    logic_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        logic_mode |-> (rdata[DATA_W-1:1] == '0));

endmodule

// File: rtl/lutcell_ctrl.sv
module lutcell_ctrl
    import lutcell_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  cell_mode_t mode_in,
    output cell_mode_t mode_q,
    output logic       join_eff
);
    cell_mode_t mode_d;

    always_comb begin
        mode_d = mode_q;
        if (load) begin
            mode_d = mode_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Joining only applies while both halves hold memory
    always_comb begin
        join_eff = mode_q.joined && !mode_q.logic_a && !mode_q.logic_b;
    end

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(mode_q));

    // R10
    mode_capture_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (mode_q == $past(mode_in)));

endmodule

// File: rtl/lut_pair_cell.sv
module lut_pair_cell
    import lutcell_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int HALF_W = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_load,
    input  logic                  cfg_logic_a,
    input  logic                  cfg_logic_b,
    input  logic                  cfg_join,
    input  logic [ADDR_W:0]       a_in,
    input  logic [ADDR_W:0]       b_in,
    input  logic [2*HALF_W-1:0]   wd,
    input  logic                  wpe,
    output logic [2*HALF_W-1:0]   f
);
    localparam int HALVES = 2;

    cell_mode_t mode_in, mode_q;
    logic       join_eff;

    logic [ADDR_W-1:0] addr_h  [HALVES];
    logic              msb_h   [HALVES];
    logic              logic_h [HALVES];
    logic [HALF_W-1:0] rd_h    [HALVES];

    always_comb begin
        mode_in.logic_a = cfg_logic_a;
        mode_in.logic_b = cfg_logic_b;
        mode_in.joined  = cfg_join;
    end

    lutcell_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_load),
        .mode_in  (mode_in),
        .mode_q   (mode_q),
        .join_eff (join_eff)
    );

    // Per-half input steering; B borrows A's address when joined
    always_comb begin
        addr_h[0]  = a_in[ADDR_W-1:0];
        msb_h[0]   = a_in[ADDR_W];
        logic_h[0] = mode_q.logic_a;
        addr_h[1]  = join_eff ? a_in[ADDR_W-1:0] : b_in[ADDR_W-1:0];
        msb_h[1]   = b_in[ADDR_W];
        logic_h[1] = mode_q.logic_b;
    end

    for (genvar g = 0; g < HALVES; g++) begin : g_half
        lut_half #(
            .ADDR_W (ADDR_W),
            .DATA_W (HALF_W)
        ) u_half (
            .clk        (clk),
            .rst        (rst),
            .logic_mode (logic_h[g]),
            .addr       (addr_h[g]),
            .msb_in     (msb_h[g]),
            .wpe        (wpe),
            .wdata      (wd[g*HALF_W +: HALF_W]),
            .rdata      (rd_h[g])
        );
        assign f[g*HALF_W +: HALF_W] = rd_h[g];
    end

endmodule

// File: tb/tb_lut_pair_cell.sv
module tb_lut_pair_cell;

    typedef struct packed {
        logic [4:0] a;
        logic [4:0] b;
        logic [3:0] wd;
        logic       wpe;
        logic [3:0] exp;
    } vec_t;

    // Memory-mode walk from the reset state (R2 R3 R4 R5)
    localparam vec_t TBL [10] = '{
        '{5'b10011, 5'b00000, 4'b1001, 1'b1, 4'b0000},  // A[3]<=01
        '{5'b00011, 5'b10101, 4'b1110, 1'b1, 4'b0001},  // B[5]<=11
        '{5'b10011, 5'b00101, 4'b0010, 1'b0, 4'b1101},  // R4 wpe low
        '{5'b00011, 5'b00101, 4'b0000, 1'b1, 4'b1101},  // R4 enables low
        '{5'b10111, 5'b11111, 4'b0110, 1'b1, 4'b0000},  // A[7]<=10 B[15]<=01
        '{5'b00111, 5'b01111, 4'b0000, 1'b1, 4'b0110},
        '{5'b10111, 5'b01111, 4'b0001, 1'b1, 4'b0110},  // R5 old data
        '{5'b00111, 5'b01111, 4'b0000, 1'b0, 4'b0101},
        '{5'b00011, 5'b00101, 4'b0000, 1'b0, 4'b1101},
        '{5'b00000, 5'b00000, 4'b0000, 1'b0, 4'b0000}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_load, cfg_logic_a, cfg_logic_b, cfg_join;
    logic [4:0] a_in, b_in;
    logic [3:0] wd;
    logic       wpe;
    logic [3:0] f;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    lut_pair_cell dut (
        .clk         (clk),
        .rst         (rst),
        .cfg_load    (cfg_load),
        .cfg_logic_a (cfg_logic_a),
        .cfg_logic_b (cfg_logic_b),
        .cfg_join    (cfg_join),
        .a_in        (a_in),
        .b_in        (b_in),
        .wd          (wd),
        .wpe         (wpe),
        .f           (f)
    );

    task automatic drive(input logic [4:0] a, input logic [4:0] b,
                         input logic [3:0] d, input logic p);
        @(negedge clk);
        a_in = a; b_in = b; wd = d; wpe = p;
        #1;
    endtask

    task automatic check(input logic [3:0] exp, input string tag);
        total++;
        if (f !== exp) begin
            bad++;
            $display("FAIL %s: f=%b expected=%b", tag, f, exp);
        end
    endtask

    task automatic set_mode(input logic la, input logic lb, input logic j);
        @(negedge clk);
        a_in = '0; b_in = '0; wpe = 1'b0;
        cfg_logic_a = la; cfg_logic_b = lb; cfg_join = j; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    initial begin
        rst = 1'b1; cfg_load = 1'b0; cfg_logic_a = 1'b0; cfg_logic_b = 1'b0;
        cfg_join = 1'b0; a_in = '0; b_in = '0; wd = '0; wpe = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        drive(5'b00000, 5'b00000, 4'b0000, 1'b0); check(4'b0000, "R1 reset word 0");
        drive(5'b01111, 5'b00111, 4'b0000, 1'b0); check(4'b0000, "R1 reset words 15/7");

        foreach (TBL[i]) begin
            drive(TBL[i].a, TBL[i].b, TBL[i].wd, TBL[i].wpe);
            check(TBL[i].exp, $sformatf("R2 R3 R4 R5 row %0d", i));
        end

        // R6 joined operation
        set_mode(1'b0, 1'b0, 1'b1);
        drive(5'b00101, 5'b00000, 4'b0000, 1'b0); check(4'b1100, "R6 joined read word 5");
        drive(5'b11001, 5'b10000, 4'b1011, 1'b1); check(4'b0000, "R6 joined write pre-edge");
        drive(5'b01001, 5'b00000, 4'b0000, 1'b0); check(4'b1011, "R6 joined write landed");
        set_mode(1'b0, 1'b0, 1'b0);
        drive(5'b00000, 5'b01001, 4'b0000, 1'b0); check(4'b1000, "R6 B word 9 written");
        drive(5'b00000, 5'b00000, 4'b0000, 1'b0); check(4'b0000, "R6 B word 0 untouched");

        // R7 R8 R9 half A in logic mode, B memory
        set_mode(1'b1, 1'b0, 1'b0);
        drive(5'b00011, 5'b00101, 4'b0000, 1'b0); check(4'b1101, "R7 R9 A logic in=3");
        drive(5'b10011, 5'b00000, 4'b0000, 1'b0); check(4'b0000, "R7 A logic in=19");
        drive(5'b11001, 5'b00000, 4'b0000, 1'b0); check(4'b0001, "R7 A logic in=25");
        drive(5'b10000, 5'b00000, 4'b0011, 1'b1); check(4'b0000, "R8 A logic write try");
        drive(5'b10000, 5'b00000, 4'b0000, 1'b0); check(4'b0000, "R8 A word 0 bit1 kept");
        drive(5'b00000, 5'b00000, 4'b0000, 1'b0); check(4'b0000, "R8 A word 0 bit0 kept");

        // R9 join ignored while A is logic
        set_mode(1'b1, 1'b0, 1'b1);
        drive(5'b00000, 5'b01001, 4'b0000, 1'b0); check(4'b1000, "R9 join ignored");
        drive(5'b00000, 5'b10010, 4'b1100, 1'b1); check(4'b0000, "R9 B write pre-edge");
        drive(5'b00000, 5'b00010, 4'b0000, 1'b0); check(4'b1100, "R9 B write landed");

        // R7 half B in logic mode
        set_mode(1'b0, 1'b1, 1'b0);
        drive(5'b00011, 5'b11001, 4'b0000, 1'b0); check(4'b0101, "R7 B logic in=25");
        drive(5'b00011, 5'b01001, 4'b0000, 1'b0); check(4'b0001, "R7 B logic in=9");

        // R10 settings retained without load
        @(negedge clk);
        cfg_logic_b = 1'b0;
        drive(5'b00000, 5'b11001, 4'b0000, 1'b0); check(4'b0100, "R10 mode retained");
        set_mode(1'b0, 1'b0, 1'b0);
        drive(5'b00000, 5'b01001, 4'b0000, 1'b0); check(4'b1000, "R10 back to memory");
        drive(5'b00000, 5'b00000, 4'b0000, 1'b0); check(4'b0000, "R8 A word 0 still 00");

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(5'b01001, 5'b00101, 4'b0000, 1'b0); check(4'b0000, "R1 contents cleared");
        drive(5'b00011, 5'b01001, 4'b0000, 1'b0); check(4'b0000, "R1 contents cleared 2");

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R1: run hung, actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule